// File: doc/BRIEF.md
# Frame Alternation Error Checker

This receive-side block watches a stream of frame-aligned, already decoded frames. Each frame arrives in one cycle with a valid strobe, a two-bit kind tag, the recovered flag bit and the raw coding-field bits. For data frames the flag must flip from one data frame to the next. A repeated flag means the receiver has probably locked onto a false frame boundary, or that the line has corrupted the frame. The block also compares the coding field against the single legal pattern for the frame's kind and flag. This catches any single-bit error in those bits and any frame that has no master transition at the centre of the field.

The checker raises a one-cycle error pulse for each bad frame and keeps a sticky copy of it. A higher layer reacts to these, typically by restarting the link. The restart input brings the checker back to its unseeded state. While the flag-select configuration input is high, the flag carries user data, so the alternation rule is switched off. The coding-field check stays active in that mode.

Top module: `fac_checker`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, both `err_pulse` and `err_sticky` are 0 after that edge, and the checker is left unseeded.
- R2: After reset, after restart, or after a cycle with `flagsel_mode` high, the first data frame that has a valid code sets the reference flag and produces no error.
- R3: Once seeded, a valid-coded data frame with the same flag as the reference raises an error, and one with the opposite flag does not. In both cases the received flag becomes the new reference.
- R4: Control frames (kind 2'b01) and fill frames (kind 2'b10) with a valid code raise no error and leave the reference and its seeded state unchanged. Data frames use kind 2'b00.
- R5: While `flagsel_mode` is high, no data frame raises an alternation error, and the checker becomes unseeded.
- R6: The code must match exactly, bit 3 first on the line (CW=4): data flag 0 is 4'b1100, data flag 1 is 4'b0011, control is 4'b1010, fill is 4'b0011. Any other value is an error, so any single flipped bit is detected. Kind 2'b11 is always an error. This check also applies in flag-select mode.
- R7: A data frame with a code error does not seed the checker and does not change the reference.
- R8: `err_pulse` is high for exactly the cycle after the edge that sampled an erroneous frame with `frm_valid` high. It is low in every other cycle, including cycles with `frm_valid` low, whatever the other inputs carry.
- R9: `err_sticky` rises together with the first `err_pulse` and stays high until reset or restart.
- R10: `restart` is synchronous. A cycle with `restart` high clears `err_pulse`, `err_sticky` and the seeded state, and a frame in that same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Link restart request, synchronous |
| flagsel_mode | input | 1 | Flag carries user data; alternation check off |
| frm_valid | input | 1 | A frame is presented this cycle |
| frm_kind | input | 2 | 00 data, 01 control, 10 fill, 11 reserved |
| frm_flag | input | 1 | Recovered flag bit |
| frm_code | input | CW (4) | Coding-field bits, MSB first on the line |
| err_pulse | output | 1 | One-cycle error per bad frame |
| err_sticky | output | 1 | Latched error, cleared by reset or restart |

## Verification
The bench builds the block with its default coding-field width of four bits. At that width the bench can flip every position of every legal code in a short loop and confirm that each flip is caught. The narrow width also lets the bench write the four legal codes as literal constants, independent of how the design derives them. Around these flips the bench interleaves control and fill frames, flag-select phases, restarts that collide with frames, and idle cycles that carry junk on the inputs. This shows that seeding, the reference update and the sticky state follow the rules.

// File: rtl/fac_pkg.sv
// Package: shared frame-kind encoding for the frame alternation checker.
// Assumes the kind tag comes from an upstream decoder as a two-bit code.
package fac_pkg;
    typedef enum logic [1:0] {
        FK_DATA = 2'b00,
        FK_CTRL = 2'b01,
        FK_FILL = 2'b10,
        FK_RSVD = 2'b11
    } frame_kind_e;
endpackage

// File: rtl/fac_code_check.sv
// Module: fac_code_check
// Compares a coding field with the single legal pattern for its frame kind
// and flag. A data field carries its flag as a complement pair of halves, a
// control field alternates, and a fill field has one rising edge at the
// centre. Every legal pattern changes level between bit HALF and bit HALF-1
// (the master transition), and because the comparison is exact, any single
// flipped bit is caught. Assumes CW is even and at least 4. Purely
// combinational.
module fac_code_check
    import fac_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [1:0]    kind,
    input  logic          flag,
    input  logic [CW-1:0] code,
    output logic          code_ok
);
    localparam int HALF = CW / 2;

    logic [CW-1:0] pat_d0;
    logic [CW-1:0] pat_d1;
    logic [CW-1:0] pat_ctl;
    logic [CW-1:0] pat_fill;
    logic [CW-1:0] want;

    // Build the legal patterns one bit at a time.
    for (genvar gi = 0; gi < CW; gi++) begin : g_pat
        assign pat_d0[gi]   = (gi >= HALF);
        assign pat_d1[gi]   = (gi <  HALF);
        assign pat_ctl[gi]  = (gi % 2 == 1);
        assign pat_fill[gi] = (gi <  HALF);
    end

    // Select the expected pattern and compare it exactly.
    always_comb begin
        want    = '0;
        code_ok = 1'b0;
        case (frame_kind_e'(kind))
            FK_DATA: begin want = flag ? pat_d1 : pat_d0; code_ok = (code == want); end
            FK_CTRL: begin want = pat_ctl;                code_ok = (code == want); end
            FK_FILL: begin want = pat_fill;               code_ok = (code == want); end
            default: begin want = '0;                     code_ok = 1'b0;           end
        endcase
    end
endmodule

// File: rtl/fac_flag_tracker.sv
// Module: fac_flag_tracker
// Holds the flag of the last accepted data frame and whether one has been
// seen. It flags an alternation break when an accepted data frame repeats the
// reference flag. Assumes 'take' is high only for valid-coded data frames.
module fac_flag_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic flagsel,
    input  logic take,
    input  logic flag,
    output logic alt_err,
    output logic seeded,
    output logic ref_flag
);
    // Alternation break: seeded, check enabled, and the flag is repeated.
    always_comb alt_err = take && seeded && !flagsel && (flag == ref_flag);

    // Reference state: cleared by reset, restart or flag-select mode.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            seeded   <= 1'b0;
            ref_flag <= 1'b0;
        end else if (flagsel) begin
            seeded   <= 1'b0;
        end else if (take) begin
            seeded   <= 1'b1;
            ref_flag <= flag;
        end
    end

    // R3: an accepted frame becomes the reference.
    a_r3_ref_follows: assert property (@(posedge clk) disable iff (!rst_n)
        take && !restart && !flagsel |=> seeded && (ref_flag == $past(flag)));
endmodule

// File: rtl/fac_err_reg.sv
// Module: fac_err_reg
// Registers the per-frame error pulse and its sticky copy. Assumes code_ok
// and alt_err describe the frame presented with frm_valid in the same cycle.
module fac_err_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic frm_valid,
    input  logic code_ok,
    input  logic alt_err,
    output logic err_pulse,
    output logic err_sticky
);
    logic fault;

    // A presented frame is faulty when its code is illegal or it breaks alternation.
    always_comb fault = frm_valid && (!code_ok || alt_err);

    // Pulse and sticky registers, both cleared by reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            err_pulse  <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            err_pulse  <= fault;
            err_sticky <= err_sticky | fault;
        end
    end

    a_r8_pulse_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(frm_valid));
    a_r9_pulse_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_sticky);
    a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky && !restart |=> err_sticky);
    a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !err_pulse && !err_sticky);
endmodule

// File: rtl/fac_checker.sv
// Module: fac_checker (top)
// Receive-side frame checker: verifies coding-field patterns and the
// alternation of the data-frame flag, and reports a registered error pulse
// plus a sticky error. Assumes one frame per cycle at most, already aligned.
module fac_checker
    import fac_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          flagsel_mode,
    input  logic          frm_valid,
    input  logic [1:0]    frm_kind,
    input  logic          frm_flag,
    input  logic [CW-1:0] frm_code,
    output logic          err_pulse,
    output logic          err_sticky
);
    logic code_ok;
    logic take;
    logic alt_err;
    logic seeded;
    logic ref_flag;

    fac_code_check #(.CW(CW)) u_code (
        .kind    (frm_kind),
        .flag    (frm_flag),
        .code    (frm_code),
        .code_ok (code_ok)
    );

    // Only valid-coded data frames reach the alternation tracker.
    always_comb take = frm_valid && code_ok && (frame_kind_e'(frm_kind) == FK_DATA);

    fac_flag_tracker u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .flagsel  (flagsel_mode),
        .take     (take),
        .flag     (frm_flag),
        .alt_err  (alt_err),
        .seeded   (seeded),
        .ref_flag (ref_flag)
    );

    fac_err_reg u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .frm_valid  (frm_valid),
        .code_ok    (code_ok),
        .alt_err    (alt_err),
        .err_pulse  (err_pulse),
        .err_sticky (err_sticky)
    );

    a_r6_reserved_never_ok: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && (frm_kind == 2'b11) |-> !code_ok);
    a_r5_flagsel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && flagsel_mode && code_ok |=> !err_pulse);
    a_r4_nondata_keeps_ref: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && (frm_kind != 2'b00) && !restart && !flagsel_mode
        |=> $stable(seeded) && $stable(ref_flag));
    a_r2_seed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        take && !seeded && !restart |=> !err_pulse);
endmodule

// File: tb/fac_checker_test.sv
// Scoreboard bench: the driver computes the expected outputs for each cycle
// from the requirements and queues them; the monitor compares after each edge.
module fac_checker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       flagsel_mode = 1'b0;
    logic       frm_valid = 1'b0;
    logic [1:0] frm_kind = 2'b00;
    logic       frm_flag = 1'b0;
    logic [3:0] frm_code = 4'b0000;
    logic       err_pulse;
    logic       err_sticky;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    bit    qp[$];
    bit    qs[$];
    string qt[$];

    bit m_seeded = 1'b0;
    bit m_ref    = 1'b0;
    bit m_sticky = 1'b0;
    bit fs       = 1'b0;

    fac_checker #(.CW(4)) uut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .flagsel_mode(flagsel_mode),
        .frm_valid(frm_valid), .frm_kind(frm_kind), .frm_flag(frm_flag),
        .frm_code(frm_code), .err_pulse(err_pulse), .err_sticky(err_sticky)
    );

    always #5 clk = ~clk;

    function automatic logic [3:0] good(input logic [1:0] k, input logic f);
        case (k)
            2'b00:   return f ? 4'b0011 : 4'b1100;
            2'b01:   return 4'b1010;
            2'b10:   return 4'b0011;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus plus the expected result it implies.
    task automatic step(input logic v, input logic [1:0] k, input logic f,
                        input logic [3:0] c, input logic rs, input string tag);
        bit ok, alt, ep;
        @(negedge clk);
        frm_valid = v; frm_kind = k; frm_flag = f; frm_code = c;
        restart = rs; flagsel_mode = fs;
        ok  = (k != 2'b11) && (c == good(k, f));
        alt = v && ok && (k == 2'b00) && !fs && m_seeded && (f == m_ref);
        ep  = v && (!ok || alt);
        if (rs) begin
            ep = 1'b0; m_seeded = 1'b0; m_ref = 1'b0; m_sticky = 1'b0;
        end else begin
            if (fs) m_seeded = 1'b0;
            else if (v && ok && k == 2'b00) begin m_seeded = 1'b1; m_ref = f; end
            m_sticky = m_sticky | ep;
        end
        qp.push_back(ep); qs.push_back(m_sticky); qt.push_back(tag);
    endtask

    task automatic frame(input logic [1:0] k, input logic f, input string tag);
        step(1'b1, k, f, good(k, f), 1'b0, tag);
    endtask

    // Monitor: compares outputs just after each edge with the queued values.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (qp.size() > 0) begin
                bit p, s;
                string t;
                p = qp.pop_front(); s = qs.pop_front(); t = qt.pop_front();
                chk(err_pulse, p, t, "err_pulse");
                chk(err_sticky, s, t, "err_sticky");
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(err_pulse, 1'b0, "R1", "reset err_pulse");
        chk(err_sticky, 1'b0, "R1", "reset err_sticky");
        @(negedge clk); rst_n = 1'b1;

        // R2 seed, R3 alternation
        frame(2'b00, 1'b1, "R2");
        frame(2'b00, 1'b0, "R3");
        frame(2'b00, 1'b0, "R3");
        frame(2'b00, 1'b1, "R3");
        // R4 control and fill leave the reference alone
        frame(2'b00, 1'b0, "R4");
        frame(2'b01, 1'b0, "R4");
        frame(2'b10, 1'b1, "R4");
        frame(2'b00, 1'b0, "R4");
        frame(2'b00, 1'b1, "R4");
        // R8 idle cycles with junk
        step(1'b0, 2'b11, 1'b1, 4'b0110, 1'b0, "R8");
        step(1'b0, 2'b00, 1'b1, 4'b0011, 1'b0, "R8");
        // R6 every single-bit flip of every legal code
        for (int b = 0; b < 4; b++) begin
            step(1'b1, 2'b00, 1'b0, good(2'b00, 1'b0) ^ (4'b1 << b), 1'b0, "R6");
            step(1'b1, 2'b00, 1'b1, good(2'b00, 1'b1) ^ (4'b1 << b), 1'b0, "R6");
            step(1'b1, 2'b01, 1'b0, good(2'b01, 1'b0) ^ (4'b1 << b), 1'b0, "R6");
            step(1'b1, 2'b10, 1'b0, good(2'b10, 1'b0) ^ (4'b1 << b), 1'b0, "R6");
        end
        step(1'b1, 2'b11, 1'b0, 4'b1100, 1'b0, "R6");
        // R7 code-errored data frame leaves reference at 1
        step(1'b1, 2'b00, 1'b0, 4'b1101, 1'b0, "R7");
        frame(2'b00, 1'b0, "R7");
        // R9 sticky holds through idle
        step(1'b0, 2'b00, 1'b0, 4'b0000, 1'b0, "R9");
        step(1'b0, 2'b00, 1'b0, 4'b0000, 1'b0, "R9");
        // R10 restart with a colliding bad frame
        step(1'b1, 2'b11, 1'b0, 4'b0000, 1'b1, "R10");
        frame(2'b00, 1'b0, "R10");
        frame(2'b00, 1'b0, "R10");
        // R5 flag-select mode
        fs = 1'b1;
        frame(2'b00, 1'b1, "R5");
        frame(2'b00, 1'b1, "R5");
        frame(2'b00, 1'b1, "R5");
        step(1'b1, 2'b00, 1'b1, 4'b0111, 1'b0, "R5");
        fs = 1'b0;
        frame(2'b00, 1'b1, "R2");
        frame(2'b00, 1'b1, "R3");
        step(1'b0, 2'b00, 1'b0, 4'b0000, 1'b0, "R8");
        step(1'b0, 2'b00, 1'b0, 4'b0000, 1'b0, "R9");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule